// File: doc/BRIEF.md
# One-Shot Pulse Timer

This block holds a 16-bit up-counter that stays parked until it is armed and a qualifying edge appears on an external trigger pin. The armed counter waits at zero. After a selected edge it clears, counts prescaled ticks, and drives exactly one pulse on its output. The pulse starts after a programmable delay and ends at a second programmable count. When the pulse ends, the counter goes back to waiting for the next trigger. Two single-cycle strobes mark the start-compare match and the end-compare match.

Software loads both compare values and the edge selection through a small write port, then sets the enable bit. The prescale select may be written in the same write that sets the enable bit. Clearing the enable bit stops counting at once and forces the output inactive.

Top module: `oneshot_timer`

## Requirements
- R1: After reset, pulse_o, irq_end_o and irq_start_o are low.
- R2: Write address 0 is control, where bit 0 is enable, bits 3:1 are the prescale select s and bits 5:4 are the edge select. Address 1 holds the end compare E and address 2 holds the start compare S.
- R3: Setting enable places the block in a waiting state. No pulse and no strobe occurs until a selected trigger edge arrives.
- R4: Edge select 00 ignores the trigger, 01 takes rising edges, 10 takes falling edges and 11 takes both. The pin passes through two synchronizer flops, and the count starts from zero on the third clock edge after the pin changes.
- R5: With s = 0, pulse_o rises on the (S+4)-th rising clock edge after the trigger pin changes.
- R6: pulse_o stays high for (E - S) count ticks and then returns low.
- R7: irq_start_o is a one-cycle strobe on the edge where the count S is matched. irq_end_o is a one-cycle strobe on the edge where the count E is matched, which coincides with the fall of pulse_o.
- R8: After the end match, the counter clears and returns to waiting, and a later trigger produces another pulse.
- R9: A trigger edge that arrives while a pulse sequence is running is ignored.
- R10: If S is not less than E, no pulse is produced, but irq_end_o still fires once.
- R11: Clearing enable forces pulse_o low from the next cycle and stops counting, so no further strobes occur.
- R12: The counter advances once every 2^s clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 16 | Register write data |
| trig_i | input | 1 | External trigger pin, asynchronous |
| pulse_o | output | 1 | One-shot pulse output |
| irq_end_o | output | 1 | End-compare match strobe |
| irq_start_o | output | 1 | Start-compare match strobe |

## Verification
The trigger is driven with rising, falling and both-edge patterns under each edge select. This separates an edge that is taken from one that is ignored, and an off select from a working one. Clock counts to the rise and fall of the pulse separate an off-by-one in the synchronizer, the delay compare or the end compare. A slower prescale setting shows whether the width scales with the tick rate. Extra triggers during a pulse, equal or inverted compare values, and a mid-pulse disable exercise the ignore, degenerate-compare and forced-stop paths.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned SEL_W = 3;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_END   = 2'd1;
  localparam logic [1:0] ADDR_START = 2'd2;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } os_state_e;
endpackage

// File: rtl/os_prescale.sv
module os_prescale #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask   = ~({PRE_W{1'b1}} << sel_i);
  assign tick_o = en_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (!en_i) pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/os_trig_detect.sv
module os_trig_detect
  import oneshot_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      trig_i,
  input  edge_sel_e sel_i,
  output logic      evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   rise, fall;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= trig_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & last_q;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: evt_o = rise;
      EDGE_FALL: evt_o = fall;
      EDGE_BOTH: evt_o = rise | fall;
      default:   evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/os_core.sv
module os_core
  import oneshot_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] cmp_end_i,
  input  logic [CNT_W-1:0] cmp_start_i,
  output logic             out_o,
  output logic             irq_end_o,
  output logic             irq_start_o,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o
);
  os_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             out_q, irq_end_q, irq_start_q;
  logic             hit_end, hit_start;

  assign hit_end   = (state_q == ST_RUN) && tick_i && (cnt_q == cmp_end_i);
  assign hit_start = (state_q == ST_RUN) && tick_i && (cnt_q == cmp_start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      out_q       <= 1'b0;
      irq_end_q   <= 1'b0;
      irq_start_q <= 1'b0;
    end else if (!en_i) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      out_q       <= 1'b0;
      irq_end_q   <= 1'b0;
      irq_start_q <= 1'b0;
    end else begin
      irq_end_q   <= hit_end;
      irq_start_q <= hit_start;
      unique case (state_q)
        ST_IDLE: state_q <= ST_WAIT;
        ST_WAIT: if (evt_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (hit_end) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
            out_q   <= 1'b0;
          end else begin
            if (tick_i)    cnt_q <= cnt_q + 1'b1;
            if (hit_start) out_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_o       = out_q & en_i;
  assign irq_end_o   = irq_end_q;
  assign irq_start_o = irq_start_q;
  assign run_o       = (state_q == ST_RUN);
  assign cnt_o       = cnt_q;
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [15:0] wr_data_i,
  input  logic        trig_i,
  output logic        pulse_o,
  output logic        irq_end_o,
  output logic        irq_start_o
);
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  edge_sel_e        edge_q;
  logic [CNT_W-1:0] cmp_end_q, cmp_start_q;
  logic             tick_w, evt_w, run_w;
  logic [CNT_W-1:0] cnt_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      sel_q       <= '0;
      edge_q      <= EDGE_OFF;
      cmp_end_q   <= '0;
      cmp_start_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_CTRL: begin
          en_q   <= wr_data_i[0];
          sel_q  <= wr_data_i[SEL_W:1];
          edge_q <= edge_sel_e'(wr_data_i[5:4]);
        end
        ADDR_END:   cmp_end_q   <= wr_data_i[CNT_W-1:0];
        ADDR_START: cmp_start_q <= wr_data_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  os_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_q), .sel_i(sel_q), .tick_o(tick_w)
  );

  os_trig_detect #(.SYNC_STAGES(2)) u_trig (
    .clk_i (clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .sel_i(edge_q), .evt_o(evt_w)
  );

  os_core #(.CNT_W(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_q),
    .tick_i      (tick_w),
    .evt_i       (evt_w),
    .cmp_end_i   (cmp_end_q),
    .cmp_start_i (cmp_start_q),
    .out_o       (pulse_o),
    .irq_end_o   (irq_end_o),
    .irq_start_o (irq_start_o),
    .run_o       (run_w),
    .cnt_o       (cnt_w)
  );
endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        run_i,
  input logic [15:0] cnt_i,
  input logic        pulse_i,
  input logic        irq_end_i,
  input logic        irq_start_i
);
  a_r3_idle_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !$past(run_i)) |-> !pulse_i);
  a_r4_start_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (cnt_i == 16'd0));
  a_r7_end_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_end_i |=> !irq_end_i);
  a_r7_end_drops_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_end_i |-> !pulse_i);
  a_r8_end_leaves_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_end_i |-> !run_i);
  a_r10_equal_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_end_i && irq_start_i) |-> !pulse_i);
  a_r11_disable_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!run_i && !irq_end_i && !irq_start_i));
endmodule

bind oneshot_timer oneshot_timer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_q),
  .run_i       (run_w),
  .cnt_i       (cnt_w),
  .pulse_i     (pulse_o),
  .irq_end_i   (irq_end_o),
  .irq_start_i (irq_start_o)
);

// File: tb/oneshot_timer_bench.sv
`timescale 1ns/1ps
module oneshot_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trig = 1'b0;
  logic        pulse, irq_end, irq_start;

  int n_chk = 0;
  int n_fail = 0;

  int o_rise, o_high, o_n0, o_n1, o_f0, o_f1;

  always #5 clk = ~clk;

  oneshot_timer u_oneshot_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .trig_i(trig), .pulse_o(pulse),
    .irq_end_o(irq_end), .irq_start_o(irq_start)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // ctrl: bit0 enable, bits3:1 prescale select, bits5:4 edge select
  task automatic setup(input int s, input int e, input int sel, input int edg);
    wr(2'd0, 16'd0);
    wr(2'd2, 16'(s));
    wr(2'd1, 16'(e));
    wr(2'd0, 16'((edg << 4) | (sel << 1) | 1));
    repeat (3) @(negedge clk);
  endtask

  // act_kind: 1 toggles the trigger, 2 writes enable low, at iteration act_k
  task automatic observe(input int n, input int act_k, input int act_kind);
    o_rise = -1; o_high = 0; o_n0 = 0; o_n1 = 0; o_f0 = -1; o_f1 = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (pulse) begin o_high++; if (o_rise < 0) o_rise = i; end
      if (irq_end) begin o_n0++; if (o_f0 < 0) o_f0 = i; end
      if (irq_start) begin o_n1++; if (o_f1 < 0) o_f1 = i; end
      if (i == act_k && act_kind == 1) trig = ~trig;
      if (i == act_k && act_kind == 2) begin
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'd0;
      end
    end
  endtask

  task automatic t_reset();
    check("R1 pulse", int'(pulse), 0);
    check("R1 irq_end", int'(irq_end), 0);
    check("R1 irq_start", int'(irq_start), 0);
  endtask

  task automatic t_basic_rise();
    setup(3, 8, 0, 1);
    observe(10, 0, 0);
    check("R3 no pulse while waiting", o_high, 0);
    check("R3 no strobe while waiting", o_n0 + o_n1, 0);
    trig = 1'b1;
    observe(30, 0, 0);
    check("R5 rise delay", o_rise, 7);
    check("R6 width", o_high, 5);
    check("R7 irq_start count", o_n1, 1);
    check("R7 irq_start at rise", o_f1, 7);
    check("R7 irq_end count", o_n0, 1);
    check("R7 irq_end at fall", o_f0, 12);
    trig = 1'b0;
    observe(10, 0, 0);
    check("R4 falling ignored under rising select", o_high, 0);
  endtask

  task automatic t_falling();
    setup(2, 6, 0, 2);
    trig = 1'b1;
    observe(20, 0, 0);
    check("R4 rising ignored under falling select", o_n0, 0);
    trig = 1'b0;
    observe(20, 0, 0);
    check("R4 falling edge delay", o_rise, 6);
    check("R4 falling edge width", o_high, 4);
  endtask

  task automatic t_off();
    setup(2, 6, 0, 0);
    trig = 1'b1;
    observe(15, 0, 0);
    trig = 1'b0;
    observe(15, 0, 0);
    check("R4 edge select off ignores trigger", o_n0 + o_n1 + o_high, 0);
  endtask

  task automatic t_both_rearm();
    setup(1, 4, 0, 3);
    trig = 1'b1;
    observe(15, 0, 0);
    check("R4 both-edge rising pulse", o_high, 3);
    trig = 1'b0;
    observe(15, 0, 0);
    check("R8 second pulse after rearm", o_high, 3);
    check("R8 second pulse delay", o_rise, 5);
  endtask

  task automatic t_retrig();
    setup(2, 12, 0, 3);
    trig = ~trig;
    observe(40, 8, 1);
    check("R9 single end strobe", o_n0, 1);
    check("R9 width unchanged", o_high, 10);
  endtask

  task automatic t_degenerate();
    setup(8, 8, 0, 1);
    trig = 1'b0; observe(3, 0, 0);
    trig = 1'b1;
    observe(25, 0, 0);
    check("R10 equal compares no pulse", o_high, 0);
    check("R10 equal compares end strobe", o_n0, 1);
    setup(9, 5, 0, 1);
    trig = 1'b0; observe(3, 0, 0);
    trig = 1'b1;
    observe(25, 0, 0);
    check("R10 start above end no pulse", o_high, 0);
    check("R10 start above end end strobe", o_n0, 1);
    check("R10 start above end no start strobe", o_n1, 0);
  endtask

  task automatic t_prescale();
    setup(2, 5, 2, 1);
    trig = 1'b0; observe(3, 0, 0);
    trig = 1'b1;
    observe(60, 0, 0);
    check("R12 width scales by 4", o_high, 12);
    check("R12 one end strobe", o_n0, 1);
  endtask

  task automatic t_disable();
    setup(2, 20, 0, 1);
    trig = 1'b0; observe(3, 0, 0);
    trig = 1'b1;
    observe(40, 10, 2);
    check("R11 pulse cut after disable", o_high, 5);
    check("R11 no end strobe after disable", o_n0, 0);
    check("R2 start strobe before disable", o_n1, 1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic_rise();
    t_falling();
    t_off();
    t_both_rearm();
    t_retrig();
    t_degenerate();
    t_prescale();
    t_disable();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule